// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block sends frames of 8 to 16 bits over a clocked serial link. Software-side logic writes a word into a one-entry holding buffer. When the shifter is free and no overrun is pending, the word moves into the shift register and goes out on `sdo`. A word written while a frame is in flight waits in the buffer. When the current frame finishes, that word is handed over at the final clock edge, so the next frame follows with no gap.

In master mode the block drives the serial clock itself. That clock comes from the system clock through a programmable divider. In slave mode the block follows an external clock on `sck_in` and drives only data. Four settings are programmable: clock idle level, clock phase, bit order and frame length. Two flags give the state: `buf_empty` shows the holding buffer is free, and `tx_end` records that the link has drained. Each flag has a one-cycle interrupt pulse with its own enable.

Top module: `sync_ser_tx`

## Requirements
- R1: A frame carries `frame_len` bits. Values below 8 are treated as 8, and values above 16 are treated as 16.
- R2: With `lsb_first`=1 bit 0 of the word is sent first. With `lsb_first`=0 bit (length-1) is sent first.
- R3: Each bit has a leading edge (the clock leaves its idle level) and a trailing edge (the clock returns to idle). With `cpha`=0, `sdo` changes on the leading edge of each bit. With `cpha`=1, the first bit is driven when the word is loaded and later bits change on trailing edges. In both cases `sdo` is stable at the opposite edge.
- R4: In master mode `sck_oe`=1, and `sck_out` toggles once every `clk_div`+1 system cycles while a frame runs. Whenever no frame runs, `sck_out` sits at the level `cpol`.
- R5: In slave mode `sck_oe`=0, and the bits are timed by the edges of `sck_in`, whose idle level is `cpol`.
- R6: A write accepted with `tx_en`=1 clears `buf_empty`. If the shifter is idle and `overrun`=0, the word enters the shifter one cycle later. `buf_empty` then returns to 1 and `irq_empty` pulses for one cycle if `ie_empty`=1.
- R7: A write with `tx_en`=0 is ignored: `buf_empty` stays 1 and no frame starts.
- R8: A word waiting in the buffer at the last trailing edge starts the next frame at once. The next leading edge comes `clk_div`+1 cycles later, as inside a frame, and `tx_end` does not set.
- R9: If the last bit ends with the buffer empty, `tx_end` sets and holds, and `irq_end` pulses once if `ie_end`=1.
- R10: `tx_end` is cleared by a `tend_clr` pulse or by an accepted write.
- R11: While `overrun`=1 no frame starts. A buffered word is kept and starts once `overrun` falls.
- R12: Dropping `tx_en` mid-frame aborts the frame. Within two cycles `sck_out` is back at idle, `sdo` keeps its last value, and `tx_end` does not set.
- R13: After reset `buf_empty`=1, `tx_end`=0, `sdo`=1, `sck_out`=`cpol`, and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; low aborts and blocks writes |
| master | input | 1 | 1 = drive serial clock, 0 = follow `sck_in` |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select (see R3) |
| lsb_first | input | 1 | Bit order select |
| frame_len | input | 5 | Bits per frame, 8 to 16 |
| clk_div | input | 8 | Master half-period minus one, in system cycles |
| ie_empty | input | 1 | Enable for `irq_empty` |
| ie_end | input | 1 | Enable for `irq_end` |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 16 | Word to send |
| tend_clr | input | 1 | Clears `tx_end` |
| overrun | input | 1 | Pending overrun; blocks frame starts |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for `sck_out` |
| sdo | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding buffer free |
| tx_end | output | 1 | Link drained after last bit |
| irq_empty | output | 1 | One-cycle buffer-empty interrupt |
| irq_end | output | 1 | One-cycle transmit-end interrupt |

## Verification
A wrong bit index or order select appears as a wrong received word within the first frame that exercises it. A lost handoff shows in three ways: a missing frame, a stretched clock gap between frames, or a spurious `tx_end` at the frame boundary. All of these are visible within one frame time. Flag faults (a stuck `buf_empty`, an overrun that fails to block, a `tx_end` that does not clear) show on the flag pins within one or two system cycles of the write or clear that should have changed them.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
    // One-cycle clock events seen by the frame sequencer
    typedef struct packed {
        logic lead;   // clock leaves its idle level
        logic trail;  // clock returns to its idle level
    } sck_evt_t;
endpackage

// File: rtl/sstx_bitsel.sv
module sstx_bitsel #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  word,
    input  logic [IW-1:0] idx,
    input  logic [IW-1:0] lenm1,
    input  logic          lsb_first,
    output logic          bit_o
);
    logic [IW-1:0] pos;
    always_comb begin
        pos   = lsb_first ? idx : IW'(lenm1 - idx);
        bit_o = word[pos];
    end
endmodule

// File: rtl/sstx_sck_gen.sv
module sstx_sck_gen
    import sstx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             master,
    input  logic             idle_lvl,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_in,
    output logic             sck_o,
    output sck_evt_t         evt
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
        logic             s1;
        logic             s2;
        logic             s3;
    } gen_t;

    gen_t q, d;
    logic tick, chg;

    always_comb begin
        d    = q;
        d.s1 = sck_in;
        d.s2 = q.s1;
        d.s3 = q.s2;
        tick = run && master && (q.cnt == div);
        chg  = run && !master && (q.s2 != q.s3);
        if (!run) begin
            d.cnt = '0;
            d.sck = idle_lvl;
        end else if (master) begin
            if (tick) begin
                d.cnt = '0;
                d.sck = !q.sck;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        evt.lead  = (tick && (q.sck == idle_lvl)) || (chg && (q.s2 != idle_lvl));
        evt.trail = (tick && (q.sck != idle_lvl)) || (chg && (q.s2 == idle_lvl));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, sck: 1'b1, s1: 1'b1, s2: 1'b1, s3: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sck_o = q.sck;

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sck_o == $past(idle_lvl))) else $error("sck not idle"); // R4
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sstx_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int MIN_BITS = 8,
    parameter int DIV_W    = 8,
    localparam int IDX_W   = $clog2(MAX_BITS),
    localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                master,
    input  logic                cpol,
    input  logic                cpha,
    input  logic                lsb_first,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [DIV_W-1:0]    clk_div,
    input  logic                ie_empty,
    input  logic                ie_end,
    input  logic                wr_en,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic                tend_clr,
    input  logic                overrun,
    input  logic                sck_in,
    output logic                sck_out,
    output logic                sck_oe,
    output logic                sdo,
    output logic                buf_empty,
    output logic                tx_end,
    output logic                irq_empty,
    output logic                irq_end
);
    typedef struct packed {
        logic [MAX_BITS-1:0] hold;
        logic                full;
        logic                busy;
        logic                tend;
        logic [MAX_BITS-1:0] shreg;
        logic [IDX_W-1:0]    idx;
        logic                sdo;
        logic                irq_e;
        logic                irq_t;
    } st_t;

    st_t q, d;
    sck_evt_t evt;
    logic [LEN_W-1:0] len_eff;
    logic [IDX_W-1:0] lenm1, idx_nxt;
    logic bit_cur, bit_nxt, bit_first, wr_acc, can_load;

    always_comb begin
        if (frame_len < LEN_W'(MIN_BITS))      len_eff = LEN_W'(MIN_BITS);
        else if (frame_len > LEN_W'(MAX_BITS)) len_eff = LEN_W'(MAX_BITS);
        else                                   len_eff = frame_len;
        lenm1   = IDX_W'(len_eff - 1'b1);
        idx_nxt = q.idx + 1'b1;
    end

    sstx_sck_gen #(.DIV_W(DIV_W)) i_sck_gen (
        .clk(clk), .rst_n(rst_n), .run(q.busy), .master(master),
        .idle_lvl(cpol), .div(clk_div), .sck_in(sck_in),
        .sck_o(sck_out), .evt(evt)
    );

    sstx_bitsel #(.W(MAX_BITS), .IW(IDX_W)) i_sel_cur (
        .word(q.shreg), .idx(q.idx), .lenm1(lenm1),
        .lsb_first(lsb_first), .bit_o(bit_cur));
    sstx_bitsel #(.W(MAX_BITS), .IW(IDX_W)) i_sel_nxt (
        .word(q.shreg), .idx(idx_nxt), .lenm1(lenm1),
        .lsb_first(lsb_first), .bit_o(bit_nxt));
    sstx_bitsel #(.W(MAX_BITS), .IW(IDX_W)) i_sel_first (
        .word(q.hold), .idx('0), .lenm1(lenm1),
        .lsb_first(lsb_first), .bit_o(bit_first));

    always_comb begin
        d        = q;
        d.irq_e  = 1'b0;
        d.irq_t  = 1'b0;
        wr_acc   = wr_en && tx_en;
        can_load = tx_en && q.full && !overrun;

        if (!tx_en) begin
            d.busy = 1'b0;
        end else if (q.busy) begin
            if (evt.lead && !cpha) d.sdo = bit_cur;
            if (evt.trail) begin
                if (q.idx == lenm1) begin
                    if (can_load) begin
                        d.shreg = q.hold;
                        d.full  = 1'b0;
                        d.idx   = '0;
                        d.irq_e = ie_empty;
                        if (cpha) d.sdo = bit_first;
                    end else begin
                        d.busy = 1'b0;
                        if (!q.full) begin
                            d.tend  = 1'b1;
                            d.irq_t = ie_end;
                        end
                    end
                end else begin
                    d.idx = idx_nxt;
                    if (cpha) d.sdo = bit_nxt;
                end
            end
        end else if (can_load) begin
            d.shreg = q.hold;
            d.full  = 1'b0;
            d.busy  = 1'b1;
            d.idx   = '0;
            d.irq_e = ie_empty;
            if (cpha) d.sdo = bit_first;
        end

        if (tend_clr) d.tend = 1'b0;
        if (wr_acc) begin
            d.hold  = wr_data;
            d.full  = 1'b1;
            d.tend  = 1'b0;
            d.irq_e = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{hold: '0, full: 1'b0, busy: 1'b0, tend: 1'b0, shreg: '0,
                   idx: '0, sdo: 1'b1, irq_e: 1'b0, irq_t: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sck_oe    = master;
    assign sdo       = q.sdo;
    assign buf_empty = !q.full;
    assign tx_end    = q.tend;
    assign irq_empty = q.irq_e;
    assign irq_end   = q.irq_t;

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !q.busy) else $error("frame not aborted"); // R12
    AST_NO_START_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !$past(overrun)) else $error("start during overrun"); // R11
    AST_TEND_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> buf_empty) else $error("tx_end with data waiting"); // R9
    AST_IRQ_EMPTY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> (buf_empty && !$past(buf_empty))) else $error("stray irq_empty"); // R6
    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_en && buf_empty) |=> buf_empty) else $error("write accepted while disabled"); // R7
endmodule

// File: tb/test_sync_ser_tx.sv
module test_sync_ser_tx;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_en, master, cpol, cpha, lsb_first, ie_empty, ie_end;
    logic wr_en, tend_clr, overrun, sck_in;
    logic [4:0]  frame_len;
    logic [7:0]  clk_div;
    logic [15:0] wr_data;
    logic sck_out, sck_oe, sdo, buf_empty, tx_end, irq_empty, irq_end;

    int n_chk = 0, n_err = 0;
    int n_rx, n_ie, n_it, cyc = 0, last_trail, gmin, gmax;
    logic [31:0] rx;
    logic prev_sck;

    always #5 clk = ~clk;

    sync_ser_tx i_sync_ser_tx (.*);

    // fields: len[31:27] lsb[26] cpha[25] cpol[24] div[23:16] data[15:0]
    localparam logic [31:0] VEC [7] = '{
        {5'd8,  1'b1, 1'b0, 1'b1, 8'd1, 16'h00A5},
        {5'd8,  1'b0, 1'b0, 1'b1, 8'd0, 16'h0093},
        {5'd16, 1'b1, 1'b1, 1'b0, 8'd2, 16'hBEEF},
        {5'd12, 1'b0, 1'b1, 1'b1, 8'd1, 16'h0ABC},
        {5'd9,  1'b1, 1'b1, 1'b0, 8'd0, 16'h01C3},
        {5'd4,  1'b0, 1'b0, 1'b0, 8'd1, 16'h005A},
        {5'd20, 1'b1, 1'b0, 1'b1, 8'd0, 16'h8001}
    };

    always @(negedge clk) begin
        cyc++;
        if (irq_empty) n_ie++;
        if (irq_end) n_it++;
        if (master && (sck_out != prev_sck)) begin
            if (sck_out != cpol) begin
                if (last_trail >= 0) begin
                    if (cyc - last_trail < gmin) gmin = cyc - last_trail;
                    if (cyc - last_trail > gmax) gmax = cyc - last_trail;
                end
                if (cpha) begin rx[n_rx] = sdo; n_rx++; end
            end else begin
                last_trail = cyc;
                if (!cpha) begin rx[n_rx] = sdo; n_rx++; end
            end
        end
        prev_sck = sck_out;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clamp_len(input int l);
        return (l < 8) ? 8 : (l > 16) ? 16 : l;
    endfunction

    function automatic logic [31:0] ser(input logic [15:0] dw, input int len, input bit lsb);
        logic [31:0] s = '0;
        for (int i = 0; i < len; i++) s[i] = lsb ? dw[i] : dw[len-1-i];
        return s;
    endfunction

    task automatic clear_mon();
        n_rx = 0; rx = '0; n_ie = 0; n_it = 0;
        last_trail = -1; gmin = 9999; gmax = 0;
    endtask

    task automatic write_word(input logic [15:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); tend_clr = 1'b1;
        @(negedge clk); tend_clr = 1'b0;
    endtask

    task automatic wait_tend();
        for (int i = 0; i < 5000 && !tx_end; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input int l, input bit lsb, input bit ph, input bit pol, input int dv);
        @(negedge clk);
        frame_len = 5'(l); lsb_first = lsb; cpha = ph; cpol = pol; clk_div = 8'(dv);
        repeat (3) @(negedge clk);
        clear_mon();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        tx_en = 1'b0; master = 1'b1; cpol = 1'b1; cpha = 1'b0; lsb_first = 1'b1;
        frame_len = 5'd8; clk_div = 8'd1; ie_empty = 1'b1; ie_end = 1'b1;
        wr_en = 1'b0; wr_data = '0; tend_clr = 1'b0; overrun = 1'b0; sck_in = 1'b1;
        prev_sck = 1'b1;
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 buf_empty", 32'(buf_empty), 1);
        check("R13 tx_end", 32'(tx_end), 0);
        check("R13 sdo", 32'(sdo), 1);
        check("R13 sck_out", 32'(sck_out), 32'(cpol));
        check("R13 irqs", {30'd0, irq_empty, irq_end}, 0);

        // R7 write while disabled
        write_word(16'h1234);
        repeat (3) @(negedge clk);
        check("R7 buf_empty after ignored write", 32'(buf_empty), 1);
        tx_en = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 no frame", 32'(n_rx), 0);

        // table of master-mode frames: R1 R2 R3 R4 R6 R9
        for (int v = 0; v < 7; v++) begin
            int l, dv;
            logic [15:0] dw;
            l = int'(VEC[v][31:27]); dv = int'(VEC[v][23:16]); dw = VEC[v][15:0];
            setup(l, VEC[v][26], VEC[v][25], VEC[v][24], dv);
            pulse_clr();
            check("R4 sck_oe master", 32'(sck_oe), 1);
            write_word(dw);
            wait_tend();
            check("R1 bit count", 32'(n_rx), 32'(clamp_len(l)));
            check("R2 R3 serial word", rx, ser(dw, clamp_len(l), VEC[v][26]));
            check("R4 idle level", 32'(sck_out), 32'(VEC[v][24]));
            check("R4 half period", 32'(gmax), 32'(dv + 1));
            check("R6 irq_empty count", 32'(n_ie), 1);
            check("R9 tx_end and irq_end", {31'd0, tx_end} + 32'(n_it), 2);
        end

        // R11 overrun blocks start
        setup(8, 1'b1, 1'b0, 1'b1, 1);
        overrun = 1'b1;
        write_word(16'h00C6);
        repeat (30) @(negedge clk);
        check("R11 word held", 32'(buf_empty), 0);
        check("R11 no bits", 32'(n_rx), 0);
        check("R10 write cleared tx_end", 32'(tx_end), 0);
        overrun = 1'b0;
        wait_tend();
        check("R11 sent after release", rx, ser(16'h00C6, 8, 1'b1));

        // R10 clear by pulse
        pulse_clr();
        check("R10 tend_clr", 32'(tx_end), 0);

        // R8 back to back
        setup(8, 1'b1, 1'b0, 1'b1, 2);
        write_word(16'h0033);
        @(negedge clk);
        check("R6 buffer free after load", 32'(buf_empty), 1);
        write_word(16'h00E1);
        wait_tend();
        check("R8 bits", 32'(n_rx), 16);
        check("R8 stream", rx, {ser(16'h00E1, 8, 1'b1)[15:0], ser(16'h0033, 8, 1'b1)[15:0]} & 32'h0000FFFF
              | ((ser(16'h00E1, 8, 1'b1) << 8) & 32'h0000FF00) | ser(16'h0033, 8, 1'b1));
        check("R8 no gap", 32'(gmax), 3);
        check("R8 single tx_end", 32'(n_it), 1);
        check("R6 two irq_empty", 32'(n_ie), 2);

        // R12 abort
        setup(16, 1'b0, 1'b0, 1'b1, 3);
        pulse_clr();
        write_word(16'hA5C3);
        repeat (40) @(negedge clk);
        begin
            logic held;
            held = sdo;
            tx_en = 1'b0;
            repeat (2) @(negedge clk);
            check("R12 clock idle", 32'(sck_out), 1);
            repeat (10) @(negedge clk);
            check("R12 sdo held", 32'(sdo), 32'(held));
            check("R12 no tx_end", 32'(tx_end), 0);
        end
        tx_en = 1'b1;

        // R5 slave mode
        master = 1'b0;
        setup(8, 1'b0, 1'b0, 1'b1, 0);
        check("R5 sck_oe slave", 32'(sck_oe), 0);
        write_word(16'h006D);
        repeat (5) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0;
            repeat (8) @(negedge clk);
            rx[i] = sdo;
            sck_in = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R5 slave word", rx, ser(16'h006D, 8, 1'b0));
        check("R5 R9 slave tx_end", 32'(tx_end), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule